// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Access Sequencer

This block turns single-beat requests on a synchronous interface into the strobe waveforms that an asynchronous fast-page-mode DRAM expects. It presents the row half of the request address, lowers the row strobe, and then switches the shared address lines to the column half before it lowers the column strobe. The write-enable and output-enable strobes follow one of three orderings: a read, an early write, or a late write. Every access ends with a precharge phase in which both address strobes are high. The length of every phase is a clock-count parameter. Request arbitration, such as giving way to refresh, uses only the `busy` flag.

An early write lowers write-enable before the column strobe falls, so the memory never drives its outputs. A late write keeps output-enable high and lowers write-enable only after the column strobe is low. A board that ties the memory's output enable permanently active cannot use late writes, so the `cfg_oe_grounded` input turns every late-write request into an early write. A read samples the memory data at the end of the data phase. The bench then sees the data on `rd_data` with a one-cycle `rd_valid` pulse.

Top module: `fpm_cycle_gen`

## Requirements
- R1: While reset is held and just after it is released, `ras_n`, `cas_n`, `we_n` and `oe_n` are 1, and `busy`, `rd_valid` and `dq_oe` are 0.
- R2: A request is accepted when `req_valid` is 1 in a clock cycle where `busy` is 0. The row part is `req_addr[ROW_W+COL_W-1:COL_W]`, and `dram_addr` carries it when `ras_n` first reads 0, which is T_ASR+1 cycles after acceptance. The column part is `req_addr[COL_W-1:0]`, and `dram_addr` carries it when `cas_n` first reads 0, which is T_ASR+T_RAH+T_ASC+1 cycles after acceptance.
- R3: `busy` is 1 for exactly T_ASR+T_RAH+T_ASC+T_CAS+T_DAT+T_PRE cycles per access. While `busy` is 0, all four strobes are 1.
- R4: In an early write (`req_write`=1, with `req_late`=0 or `cfg_oe_grounded`=1), `we_n` falls T_ASC cycles before `cas_n` falls. `we_n` rises in the same cycle as `cas_n`. `dq_oe` is 1 only while `we_n` is 0, and `oe_n` stays 1.
- R5: In a late write (`req_write`=1, `req_late`=1, `cfg_oe_grounded`=0), `oe_n` stays 1 and `we_n` falls T_CAS cycles after `cas_n` falls. `we_n` stays 0, with `dq_out` driven, until `cas_n` rises. The written data is then read back correctly.
- R6: When `cfg_oe_grounded` is 1, a late-write request produces the early-write ordering of R4, so `we_n` never falls while `cas_n` is 0.
- R7: In a read, `we_n` stays 1 for the whole access, including precharge. `oe_n` is 0 only while `cas_n` is 0, for T_CAS+T_DAT cycles, and `dq_oe` stays 0.
- R8: A read samples `dq_in` at the last cycle of the data phase, after `cas_n` has been 0 for T_CAS+T_DAT cycles. `rd_valid` is then 1 for exactly one cycle, T_ASR+T_RAH+T_ASC+T_CAS+T_DAT+1 cycles after acceptance, with the sampled value on `rd_data`. A write gives no pulse.
- R9: `cas_n` is never 0 while `ras_n` is 1. Each access ends with T_PRE cycles in which both strobes are 1 before `busy` drops, so `ras_n` never falls before both strobes have been high for at least T_PRE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_oe_grounded | input | 1 | Board ties memory output enable active; late writes become early writes |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_late | input | 1 | Write uses late-write ordering |
| req_addr | input | ROW_W+COL_W | Row (upper) and column (lower) address |
| req_wdata | input | DQ_W | Write data |
| busy | output | 1 | Access in progress |
| rd_data | output | DQ_W | Read result |
| rd_valid | output | 1 | One-cycle read result pulse |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | DQ_W | Write data toward the memory |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | DQ_W | Data from the memory |

## Verification
A wrong state or dwell count shifts the cycle in which a strobe edge falls. It also changes how long `busy` stays high, so the bench measures every edge index against its expected value within the same access. A wrong mode bit swaps the order of the `we_n` and `cas_n` edges at once, or drops the `rd_valid` pulse. The memory model returns complemented data unless `cas_n` and `oe_n` have been low for the full access time, so sampling at the wrong moment shows up in the very next read value. Lost or misdirected writes show up when the location is read back.

// File: rtl/fpm_cycle_gen.sv
module fpm_cycle_gen #(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  parameter int DQ_W  = 4,
  parameter int T_ASR = 1,
  parameter int T_RAH = 2,
  parameter int T_ASC = 1,
  parameter int T_CAS = 2,
  parameter int T_DAT = 2,
  parameter int T_PRE = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_oe_grounded,
  input  logic                                 req_valid,
  input  logic                                 req_write,
  input  logic                                 req_late,
  input  logic [ROW_W+COL_W-1:0]               req_addr,
  input  logic [DQ_W-1:0]                      req_wdata,
  output logic                                 busy,
  output logic [DQ_W-1:0]                      rd_data,
  output logic                                 rd_valid,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0] dram_addr,
  output logic                                 ras_n,
  output logic                                 cas_n,
  output logic                                 we_n,
  output logic                                 oe_n,
  output logic [DQ_W-1:0]                      dq_out,
  output logic                                 dq_oe,
  input  logic [DQ_W-1:0]                      dq_in
);
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int CNT_W = 8;

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_RAS, S_COL, S_CAS, S_DAT, S_PRE} st_t;

  st_t              st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             is_wr, is_late;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [DQ_W-1:0]  wd_q;
  logic [MUX_W-1:0] addr_d;
  logic             we_d, oe_d, acc, done, in_col;

  function automatic logic [CNT_W-1:0] dwell(input st_t s);
    case (s)
      S_ROW:   return CNT_W'(T_ASR - 1);
      S_RAS:   return CNT_W'(T_RAH - 1);
      S_COL:   return CNT_W'(T_ASC - 1);
      S_CAS:   return CNT_W'(T_CAS - 1);
      S_DAT:   return CNT_W'(T_DAT - 1);
      S_PRE:   return CNT_W'(T_PRE - 1);
      default: return '0;
    endcase
  endfunction

  assign acc  = (st == S_IDLE) && req_valid;
  assign done = (cnt == '0);
  assign busy = (st != S_IDLE);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (req_valid) st_nx = S_ROW;
      S_ROW:  if (done) st_nx = S_RAS;
      S_RAS:  if (done) st_nx = S_COL;
      S_COL:  if (done) st_nx = S_CAS;
      S_CAS:  if (done) st_nx = S_DAT;
      S_DAT:  if (done) st_nx = S_PRE;
      S_PRE:  if (done) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  assign cnt_nx = (st_nx != st) ? dwell(st_nx) : (st == S_IDLE) ? '0 : cnt - 1'b1;

  assign in_col = (st_nx == S_COL) || (st_nx == S_CAS) || (st_nx == S_DAT);

  always_comb begin
    addr_d = '0;
    if (in_col)   addr_d[COL_W-1:0] = col_q;
    else if (acc) addr_d[ROW_W-1:0] = req_addr[ROW_W+COL_W-1:COL_W];
    else          addr_d[ROW_W-1:0] = row_q;
  end

  assign we_d = is_wr && (is_late ? (st_nx == S_DAT) : in_col);
  assign oe_d = !is_wr && ((st_nx == S_CAS) || (st_nx == S_DAT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      is_wr   <= 1'b0;
      is_late <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      wd_q    <= '0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
      dram_addr <= '0;
      rd_data <= '0;
      rd_valid <= 1'b0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
      if (acc) begin
        is_wr   <= req_write;
        is_late <= req_write && req_late && !cfg_oe_grounded;
        row_q   <= req_addr[ROW_W+COL_W-1:COL_W];
        col_q   <= req_addr[COL_W-1:0];
        wd_q    <= req_wdata;
      end
      ras_n     <= !((st_nx == S_RAS) || in_col);
      cas_n     <= !((st_nx == S_CAS) || (st_nx == S_DAT));
      we_n      <= !we_d;
      oe_n      <= !oe_d;
      dq_oe     <= we_d;
      dram_addr <= addr_d;
      rd_valid  <= (st == S_DAT) && done && !is_wr;
      if ((st == S_DAT) && done && !is_wr) rd_data <= dq_in;
    end
  end

  assign dq_out = wd_q;
endmodule

// File: rtl/fpm_cycle_gen_chk.sv
module fpm_cycle_gen_chk #(
  parameter int T_PRE = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_oe_grounded,
  input logic busy,
  input logic rd_valid,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe
);
  logic [7:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_run <= 8'(T_PRE);
    else if (ras_n && cas_n) hi_run <= (hi_run == 8'hFF) ? hi_run : hi_run + 8'd1;
    else hi_run <= '0;
  end

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !ras_n); // R9
  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> (hi_run >= 8'(T_PRE))); // R9
  AST_OE_EXCLUDES_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> (we_n && !dq_oe)); // R7
  AST_DRIVE_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> !we_n); // R4
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (ras_n && cas_n && we_n && oe_n)); // R3
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R8
  AST_GROUNDED_EARLY: assert property (@(posedge clk) disable iff (!rst_n) (cfg_oe_grounded && $fell(we_n)) |-> cas_n); // R6
endmodule

bind fpm_cycle_gen fpm_cycle_gen_chk #(.T_PRE(T_PRE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_oe_grounded(cfg_oe_grounded), .busy(busy),
  .rd_valid(rd_valid), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe)
);

// File: tb/fpm_cycle_gen_test.sv
`timescale 1ns/1ps
module fpm_cycle_gen_test;
  localparam int ROW_W = 4, COL_W = 4, DQ_W = 4;
  localparam int T_ASR = 1, T_RAH = 2, T_ASC = 1, T_CAS = 2, T_DAT = 2, T_PRE = 3;
  localparam int TOTAL   = T_ASR + T_RAH + T_ASC + T_CAS + T_DAT + T_PRE;
  localparam int RAS_IDX = T_ASR + 1;
  localparam int CAS_IDX = T_ASR + T_RAH + T_ASC + 1;
  localparam int VAL_IDX = CAS_IDX + T_CAS + T_DAT;
  localparam int DEPTH   = 1 << (ROW_W + COL_W);

  logic clk = 0, rst_n = 0, cfg = 0, req_valid = 0, req_write = 0, req_late = 0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DQ_W-1:0] req_wdata = '0, rd_data, dq_out, dq_in;
  logic busy, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [COL_W-1:0] dram_addr;

  int nchk = 0, nfail = 0;
  logic [DQ_W-1:0] ref_mem [DEPTH];
  logic [DQ_W-1:0] mem [DEPTH];
  logic [ROW_W-1:0] row_l;
  logic ras_q;
  int cas_cnt;

  always #2.5 clk = ~clk;

  fpm_cycle_gen #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .T_ASR(T_ASR), .T_RAH(T_RAH),
    .T_ASC(T_ASC), .T_CAS(T_CAS), .T_DAT(T_DAT), .T_PRE(T_PRE)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_oe_grounded(cfg), .req_valid(req_valid), .req_write(req_write),
    .req_late(req_late), .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rd_data(rd_data),
    .rd_valid(rd_valid), .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  function automatic logic [DQ_W-1:0] init_val(input int i);
    return DQ_W'((i * 5 + 3) ^ (i >> 4));
  endfunction

  // memory model: data valid only after the full access time with outputs enabled
  always @(posedge clk) begin
    ras_q   <= ras_n;
    cas_cnt <= cas_n ? 0 : cas_cnt + 1;
    if (ras_q && !ras_n) row_l <= dram_addr[ROW_W-1:0];
    if (!cas_n && !we_n && dq_oe) mem[{row_l, dram_addr}] <= dq_out;
  end
  assign dq_in = (!cas_n && !oe_n && cas_cnt >= T_CAS + T_DAT - 1) ? mem[{row_l, dram_addr}]
                                                                   : ~mem[{row_l, dram_addr}];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input bit late, input bit grounded,
                       input logic [ROW_W+COL_W-1:0] a, input logic [DQ_W-1:0] wd);
    int idx = 0, ras_i = 0, cas_i = 0, cas_last = 0, we_i = 0, we_last = 0, val_i = 0, npulse = 0;
    int oe_lo = 0, pre = 0, bad_oe = 0, bad_dq = 0, bad_cas = 0;
    int ras_a = 0, cas_a = 0, rdat = 0;
    bit eff_late = wr && late && !grounded;
    while (busy) @(negedge clk);
    cfg = grounded; req_valid = 1; req_write = wr; req_late = late; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (busy && idx < 100) begin
      idx++;
      if (!ras_n && ras_i == 0) begin ras_i = idx; ras_a = int'(dram_addr); end
      if (!cas_n && cas_i == 0) begin cas_i = idx; cas_a = int'(dram_addr); end
      if (!cas_n) cas_last = idx;
      if (!we_n && we_i == 0) we_i = idx;
      if (!we_n) we_last = idx;
      if (!oe_n) begin oe_lo++; if (cas_n) bad_oe++; end
      if (dq_oe && we_n) bad_dq++;
      if (!cas_n && ras_n) bad_cas++;
      if (ras_n && cas_n && cas_i != 0) pre++;
      if (rd_valid) begin npulse++; val_i = idx; rdat = int'(rd_data); end
      @(negedge clk);
    end
    chk(idx == TOTAL, "R3 busy length", idx, TOTAL);
    chk(ras_n && cas_n && we_n && oe_n, "R3 strobes high when idle", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(ras_i == RAS_IDX && ras_a == int'(a[7:4]), "R2 row on ras fall", ras_a, int'(a[7:4]));
    chk(cas_i == CAS_IDX && cas_a == int'(a[3:0]), "R2 col on cas fall", cas_a, int'(a[3:0]));
    chk(pre == T_PRE && bad_cas == 0, "R9 precharge cycles", pre, T_PRE);
    if (wr) begin
      chk(oe_lo == 0 && bad_dq == 0, "R4 oe high and dq only with we", oe_lo + bad_dq, 0);
      chk(npulse == 0, "R8 no pulse on write", npulse, 0);
      chk(we_last == cas_last, "R4 we rises with cas", we_last, cas_last);
      if (eff_late) chk(we_i == CAS_IDX + T_CAS, "R5 late we fall", we_i, CAS_IDX + T_CAS);
      else if (late) chk(we_i == CAS_IDX - T_ASC, "R6 grounded forces early", we_i, CAS_IDX - T_ASC);
      else chk(we_i == CAS_IDX - T_ASC, "R4 early we fall", we_i, CAS_IDX - T_ASC);
      ref_mem[a] = wd;
    end else begin
      chk(we_i == 0 && bad_dq == 0, "R7 we high in read", we_i, 0);
      chk(oe_lo == T_CAS + T_DAT && bad_oe == 0, "R7 oe under cas", oe_lo, T_CAS + T_DAT);
      chk(npulse == 1 && val_i == VAL_IDX, "R8 valid pulse timing", val_i, VAL_IDX);
      chk(rdat == int'(ref_mem[a]), "R8 read data", rdat, int'(ref_mem[a]));
    end
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin ref_mem[i] = init_val(i); mem[i] = init_val(i); end
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !busy && !rd_valid && !dq_oe, "R1 reset state",
        {ras_n, cas_n, we_n, oe_n, busy, rd_valid, dq_oe}, 120);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n && cas_n && !busy && !rd_valid && !dq_oe, "R1 after release", busy, 0);
    do_op(0, 0, 0, 8'h00, 4'h0);
    do_op(1, 0, 0, 8'hFF, 4'hA);
    do_op(0, 0, 0, 8'hFF, 4'h0);
    do_op(1, 1, 0, 8'h5A, 4'h3);
    do_op(0, 0, 0, 8'h5A, 4'h0);
    do_op(1, 1, 1, 8'hA5, 4'hC);
    do_op(0, 0, 1, 8'hA5, 4'h0);
    do_op(1, 0, 0, 8'h00, 4'hF);
    do_op(0, 0, 0, 8'h00, 4'h0);
    for (int n = 0; n < 80; n++)
      do_op(1'($urandom % 2), 1'($urandom % 2), ($urandom % 4) == 0,
            8'($urandom % DEPTH), 4'($urandom));
    for (int n = 0; n < 16; n++) do_op(0, 0, 0, 8'(n * 17), 4'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule